// File: doc/BRIEF.md
# Serial Channel Register Front End

This block is the per-channel register slice of an eight-channel asynchronous communications controller. A byte-wide host bus reaches a mode register pair, a status register, a command register and a holding register that reads received bytes and writes bytes to be sent. Two neighbouring channels form a pair that shares a block-level interrupt unit. This slice does not hold that unit's interrupt state. Instead it emits single-cycle event pulses, which the interrupt unit collects.

The bit-serial line is replaced by byte streams. Received bytes arrive on a valid/ready input and are held in a three-entry queue. A line break arrives as a flagged input beat. Bytes written for transmission leave on a valid/ready output. Several functions belong to other parts of the chip and are not in this slice: baud-rate generation, clock selection, auxiliary control and output-port setup. A write to the clock-select location is therefore accepted and discarded.

Top module: `chanregs_top`

## Requirements
- R1: The slice responds only when address bits [7:4] equal the parameter CHAN_ID. Within the slice, address bits [3:0] select a register: 0x0 is the mode register, 0x2 is status on read and clock-select on write, 0x4 is the command register, and 0x6 is the holding register. A clock-select write, any access to another nibble, and any access to another channel change nothing. A read of an unmapped or foreign location returns 0.
- R2: A mode pointer chooses between mode register 1 and mode register 2. After a pointer reset, the first mode access (read or write) reaches register 1. Every mode access then leaves the pointer on register 2, and it stays there until the next pointer reset.
- R3: Command bits 0, 1, 2 and 3 enable the receiver, disable the receiver, enable the transmitter and disable the transmitter. When a command sets both the enable and the disable bit of one direction, disable wins. Status bit 2 (transmit ready) and status bit 3 (transmit empty) are set while the transmitter is enabled and no byte is waiting.
- R4: Command bits [7:4] hold a code. Code 1 resets the mode pointer. Code 2 disables the receiver and empties the queue, and it overrides bit 0 of the same command. Code 3 disables the transmitter and drops any waiting byte. Code 4 is the error reset (R9). Code 5 pulses evtBreakAck. Every other code does nothing.
- R5: rxReady is high only while the receiver is enabled and fewer than 3 bytes are queued. Status bit 0 is set when the queue holds at least one byte. Status bit 1 is set when the queue holds 3 bytes. Input beats are not stored while rxReady is low.
- R6: A holding-register read returns the oldest queued byte and removes it, so the queue is first-in first-out across wraparound. A read of an empty queue returns the byte last removed and changes no state.
- R7: evtRxReady pulses for one cycle only when a byte enters an empty queue.
- R8: A break beat pushes the byte 0x00. If status bit 7 (break) is clear, the beat sets bit 7 and pulses evtBreak. A later holding read that removes a byte while bit 7 is set clears bit 7 and pulses evtBreak again.
- R9: Status bit 4 (overrun) is set when an input beat arrives while the receiver is enabled and the queue is full. Command code 4 clears bits 4 to 7.
- R10: A holding write while status bit 2 is set places the byte on txByte with txValid high. The byte and txValid are held, with bits 2 and 3 clear, until txReady accepts it. A holding write while bit 2 is clear is dropped. evtTxReady pulses whenever bit 2 goes from clear to set.
- R11: After reset, status reads 0x00, rxReady and txValid are low, no event is pulsing, busRdData is 0x00 and the mode pointer is on register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Host byte address |
| busWr | input | 1 | Host write strobe, one cycle per access |
| busRd | input | 1 | Host read strobe, one cycle per access |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Read result, registered |
| rxByte | input | 8 | Received byte |
| rxValid | input | 1 | Received beat valid |
| rxBreak | input | 1 | Beat is a line break rather than a byte |
| rxReady | output | 1 | Slice can store a received beat |
| txByte | output | 8 | Byte to transmit |
| txValid | output | 1 | txByte is valid |
| txReady | input | 1 | Line side accepts txByte |
| evtRxReady | output | 1 | Pulse: queue went from empty to non-empty |
| evtTxReady | output | 1 | Pulse: transmit ready became set |
| evtBreak | output | 1 | Pulse: break detected or break acknowledged by a read |
| evtBreakAck | output | 1 | Pulse: break-change interrupt reset command |

## Verification
Every host access, input beat and output handshake takes effect on the clock edge that samples it. The read result, the new status and any event pulse are all visible right after that same edge, so each result is due exactly one edge after its stimulus. The bench drives on the falling edge and samples 1 ns after the next rising edge. A read queues its expected byte, and a monitor compares that byte just after the sampling edge. Transmitted bytes go through a second queue, which is compared at each accepted handshake.

// File: rtl/chanregs_pkg.sv
`timescale 1ns/1ps
package chanregs_pkg;

  // Decoded per-access strobes from the control to the datapath.
  typedef struct packed {
    logic rdAny;
    logic modeRd;
    logic modeWr;
    logic statRd;
    logic rhrRd;
    logic thrWr;
    logic rxOn;
    logic rxOff;
    logic txOn;
    logic txOff;
    logic ptrRst;
    logic rxRst;
    logic txRst;
    logic errRst;
    logic brkAck;
  } chanStrobe_t;

  typedef enum logic [3:0] {
    CMD_NOP     = 4'd0,
    CMD_PTR_RST = 4'd1,
    CMD_RX_RST  = 4'd2,
    CMD_TX_RST  = 4'd3,
    CMD_ERR_RST = 4'd4,
    CMD_BRK_ACK = 4'd5
  } cmdCode_t;

  // Register offsets after the byte-lane swap (low address bit inverted).
  localparam logic [3:0] OFS_MODE = 4'h1;
  localparam logic [3:0] OFS_STAT = 4'h3;
  localparam logic [3:0] OFS_CMD  = 4'h5;
  localparam logic [3:0] OFS_HOLD = 4'h7;

  // Status bit positions.
  localparam int ST_RXRDY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_TXRDY = 2;
  localparam int ST_TXEMT = 3;
  localparam int ST_OVR   = 4;
  localparam int ST_PAR   = 5;
  localparam int ST_FRM   = 6;
  localparam int ST_BRK   = 7;

endpackage

// File: rtl/chanregs_rxfifo.sv
`timescale 1ns/1ps
module chanregs_rxfifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic [DATA_W-1:0]          pushData,
  input  logic                       pop,
  input  logic                       flush,
  output logic [DATA_W-1:0]          headData,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW:0]   DEPTH_S = (CW + 1)'(DEPTH);
  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IW-1:0]     rdIdx;
  logic [CW:0]       posSum;
  logic [IW-1:0]     wrPos;
  logic              doPop;
  logic              advance;

  always_comb begin
    posSum  = (CW + 1)'(rdIdx) + (CW + 1)'(count);
    wrPos   = (posSum >= DEPTH_S) ? IW'(posSum - DEPTH_S) : IW'(posSum);
    doPop   = pop && (count != '0);
    // The head index stays on the last entry when the queue drains.
    advance = doPop && ((count > CW'(1)) || push);
  end

  assign headData = mem[rdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) mem[wrPos] <= pushData;
      if (flush) begin
        count <= '0;
      end else begin
        if (advance) rdIdx <= (rdIdx == LAST_IDX) ? '0 : rdIdx + IW'(1);
        count <= count + CW'(push) - CW'(doPop);
      end
    end
  end

  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count < CW'(DEPTH))); // R5
  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (pop && count == '0 && !push && !flush) |=> ($stable(rdIdx) && count == '0)); // R6

endmodule

// File: rtl/chanregs_ctrl.sv
`timescale 1ns/1ps
module chanregs_ctrl
  import chanregs_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 8,
  parameter int unsigned CHAN_ID = 0
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWrData,
  output chanStrobe_t       strb
);
  localparam logic [ADDR_W-5:0] CHAN_SEL = CHAN_ID[ADDR_W-5:0];

  logic     hit;
  logic [3:0] ofs;
  cmdCode_t code;

  always_comb begin
    hit  = (busAddr[ADDR_W-1:4] == CHAN_SEL);
    ofs  = busAddr[3:0] ^ 4'h1;
    code = cmdCode_t'(busWrData[7:4]);
    strb = '0;
    strb.rdAny = busRd;
    if (hit && busRd) begin
      unique case (ofs)
        OFS_MODE: strb.modeRd = 1'b1;
        OFS_STAT: strb.statRd = 1'b1;
        OFS_HOLD: strb.rhrRd  = 1'b1;
        default:  ;
      endcase
    end
    if (hit && busWr) begin
      unique case (ofs)
        OFS_MODE: strb.modeWr = 1'b1;
        OFS_CMD: begin
          strb.rxOn  = busWrData[0];
          strb.rxOff = busWrData[1];
          strb.txOn  = busWrData[2];
          strb.txOff = busWrData[3];
          unique case (code)
            CMD_PTR_RST: strb.ptrRst = 1'b1;
            CMD_RX_RST:  strb.rxRst  = 1'b1;
            CMD_TX_RST:  strb.txRst  = 1'b1;
            CMD_ERR_RST: strb.errRst = 1'b1;
            CMD_BRK_ACK: strb.brkAck = 1'b1;
            default:     ;
          endcase
        end
        OFS_HOLD: strb.thrWr = 1'b1;
        default:  ;   // clock-select and unmapped writes are discarded
      endcase
    end
  end

endmodule

// File: rtl/chanregs_dp.sv
`timescale 1ns/1ps
module chanregs_dp
  import chanregs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobe_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxValid,
  input  logic              rxBreak,
  output logic              rxReady,
  output logic [DATA_W-1:0] txByte,
  output logic              txValid,
  input  logic              txReady,
  output logic              evtRxReady,
  output logic              evtTxReady,
  output logic              evtBreak,
  output logic              evtBreakAck
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0]     fifoCount;
  logic [DATA_W-1:0] headData;
  logic [DATA_W-1:0] pushData;
  logic [DATA_W-1:0] modeReg [2];
  logic [DATA_W-1:0] statusW;
  logic [DATA_W-1:0] rdMux;
  logic rxEn, txEn, txPend, brkSt, ovrSt, modePtr;
  logic rxEnN, txEnN, txPendN, brkN, ovrN, ptrN;
  logic fifoFull, fifoEmpty, accept, overrunHit, popHit, txRdy, txRdyN;

  always_comb begin
    fifoFull   = (fifoCount == FULL_CNT);
    fifoEmpty  = (fifoCount == '0);
    rxReady    = rxEn && !fifoFull;
    accept     = rxValid && rxReady;
    overrunHit = rxValid && rxEn && fifoFull;
    popHit     = strb.rhrRd && !fifoEmpty;
    pushData   = rxBreak ? '0 : rxByte;
    txRdy      = txEn && !txPend;

    statusW           = '0;
    statusW[ST_RXRDY] = !fifoEmpty;
    statusW[ST_FULL]  = fifoFull;
    statusW[ST_TXRDY] = txRdy;
    statusW[ST_TXEMT] = txRdy;
    statusW[ST_OVR]   = ovrSt;
    statusW[ST_PAR]   = 1'b0;
    statusW[ST_FRM]   = 1'b0;
    statusW[ST_BRK]   = brkSt;

    rdMux = '0;
    if (strb.modeRd)      rdMux = modeReg[modePtr];
    else if (strb.statRd) rdMux = statusW;
    else if (strb.rhrRd)  rdMux = headData;

    // Enable bits first, then the command code.
    rxEnN = rxEn;
    if (strb.rxOn)  rxEnN = 1'b1;
    if (strb.rxOff) rxEnN = 1'b0;
    if (strb.rxRst) rxEnN = 1'b0;
    txEnN = txEn;
    if (strb.txOn)  txEnN = 1'b1;
    if (strb.txOff) txEnN = 1'b0;
    if (strb.txRst) txEnN = 1'b0;

    txPendN = txPend;
    if (txValid && txReady)  txPendN = 1'b0;
    if (strb.thrWr && txRdy) txPendN = 1'b1;
    if (strb.txRst)          txPendN = 1'b0;
    txRdyN = txEnN && !txPendN;

    brkN = brkSt;
    if (popHit && brkSt)     brkN = 1'b0;
    if (accept && rxBreak)   brkN = 1'b1;
    if (strb.errRst)         brkN = 1'b0;
    ovrN = ovrSt || overrunHit;
    if (strb.errRst)         ovrN = 1'b0;

    ptrN = modePtr;
    if (strb.modeRd || strb.modeWr) ptrN = 1'b1;
    if (strb.ptrRst)                ptrN = 1'b0;
  end

  chanregs_rxfifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rxq_i (
    .clk      (clk),
    .rstN     (rstN),
    .push     (accept),
    .pushData (pushData),
    .pop      (strb.rhrRd),
    .flush    (strb.rxRst),
    .headData (headData),
    .count    (fifoCount)
  );

  assign txValid = txPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEn        <= 1'b0;
      txEn        <= 1'b0;
      txPend      <= 1'b0;
      txByte      <= '0;
      brkSt       <= 1'b0;
      ovrSt       <= 1'b0;
      modePtr     <= 1'b0;
      modeReg[0]  <= '0;
      modeReg[1]  <= '0;
      rdData      <= '0;
      evtRxReady  <= 1'b0;
      evtTxReady  <= 1'b0;
      evtBreak    <= 1'b0;
      evtBreakAck <= 1'b0;
    end else begin
      rxEn    <= rxEnN;
      txEn    <= txEnN;
      txPend  <= txPendN;
      brkSt   <= brkN;
      ovrSt   <= ovrN;
      modePtr <= ptrN;
      if (strb.thrWr && txRdy) txByte <= wrData;
      if (strb.modeWr)         modeReg[modePtr] <= wrData;
      if (strb.rdAny)          rdData <= rdMux;
      evtRxReady  <= accept && fifoEmpty && !strb.rxRst;
      evtTxReady  <= txRdyN && !txRdy;
      evtBreak    <= (accept && rxBreak && !brkSt) || (popHit && brkSt);
      evtBreakAck <= strb.brkAck;
    end
  end

  AST_RXEVT_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    evtRxReady |-> (fifoCount != '0)); // R7
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !strb.txRst) |=> (txValid && $stable(txByte))); // R10
  AST_PTR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (modePtr && !strb.ptrRst) |=> modePtr); // R2
  AST_RXRST_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxRst |=> (fifoCount == '0 && !rxReady)); // R4

endmodule

// File: rtl/chanregs_top.sv
`timescale 1ns/1ps
module chanregs_top
  import chanregs_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 8,
  parameter int          DEPTH   = 3,
  parameter int unsigned CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxValid,
  input  logic              rxBreak,
  output logic              rxReady,
  output logic [DATA_W-1:0] txByte,
  output logic              txValid,
  input  logic              txReady,
  output logic              evtRxReady,
  output logic              evtTxReady,
  output logic              evtBreak,
  output logic              evtBreakAck
);
  chanStrobe_t strb;

  chanregs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAN_ID(CHAN_ID)) ctrl_i (
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busRd     (busRd),
    .busWrData (busWrData),
    .strb      (strb)
  );

  chanregs_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (busWrData),
    .rdData      (busRdData),
    .rxByte      (rxByte),
    .rxValid     (rxValid),
    .rxBreak     (rxBreak),
    .rxReady     (rxReady),
    .txByte      (txByte),
    .txValid     (txValid),
    .txReady     (txReady),
    .evtRxReady  (evtRxReady),
    .evtTxReady  (evtTxReady),
    .evtBreak    (evtBreak),
    .evtBreakAck (evtBreakAck)
  );

endmodule

// File: tb/chanregs_tb.sv
`timescale 1ns/1ps
module chanregs_top_tb_top;
  localparam logic [7:0] MODE = 8'h30, STAT = 8'h32, CMD = 8'h34, HOLD = 8'h36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0, busWrData = '0, rxByte = '0;
  logic busWr = 1'b0, busRd = 1'b0, rxValid = 1'b0, rxBreak = 1'b0, txReady = 1'b0;
  logic [7:0] busRdData, txByte;
  logic rxReady, txValid, evtRxReady, evtTxReady, evtBreak, evtBreakAck;
  logic snRx, snTx, snBrk, snAck;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] rdQ[$];
  string      rdTagQ[$];
  logic [7:0] txQ[$];

  always #5 clk = ~clk;

  chanregs_top #(.CHAN_ID(3)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .rxByte(rxByte),
    .rxValid(rxValid), .rxBreak(rxBreak), .rxReady(rxReady), .txByte(txByte),
    .txValid(txValid), .txReady(txReady), .evtRxReady(evtRxReady),
    .evtTxReady(evtTxReady), .evtBreak(evtBreak), .evtBreakAck(evtBreakAck)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    snRx = evtRxReady; snTx = evtTxReady; snBrk = evtBreak; snAck = evtBreakAck;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    cyc();
    busWr = 1'b0;
  endtask

  task automatic readExp(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rdQ.push_back(exp); rdTagQ.push_back(tag);
    busAddr = a; busRd = 1'b1;
    cyc();
    busRd = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] b, input logic brk);
    @(negedge clk);
    rxByte = b; rxBreak = brk; rxValid = 1'b1;
    cyc();
    rxValid = 1'b0; rxBreak = 1'b0;
  endtask

  task automatic writeThr(input logic [7:0] b, input bit sent);
    if (sent) txQ.push_back(b);
    busWrite(HOLD, b);
  endtask

  // Read-data monitor: result is due right after the sampling edge.
  always @(posedge clk) begin
    if (busRd) begin
      #1;
      if (rdQ.size() == 0) chk(1'b0, "read-queue", busRdData, 0);
      else begin
        logic [7:0] e;
        string t;
        e = rdQ.pop_front(); t = rdTagQ.pop_front();
        chk(busRdData == e, t, busRdData, e);
      end
    end
  end

  // Transmit monitor: compare at each accepted handshake.
  always @(posedge clk) begin
    if (rstN && txValid && txReady) begin
      if (txQ.size() == 0) chk(1'b0, "R10 unexpected tx", txByte, 0);
      else begin
        logic [7:0] e;
        e = txQ.pop_front();
        chk(txByte == e, "R10 tx byte", txByte, e);
      end
    end
  end

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    cyc();
    // R11 reset state
    chk(rxReady == 0 && txValid == 0, "R11 rxReady/txValid", {rxReady, txValid}, 0);
    chk({snRx, snTx, snBrk, snAck} == 0, "R11 events", {snRx, snTx, snBrk, snAck}, 0);
    chk(busRdData == 0, "R11 read data", busRdData, 0);
    readExp(STAT, 8'h00, "R11 status");
    // R2 mode pointer
    busWrite(MODE, 8'h13);
    busWrite(MODE, 8'h07);
    readExp(MODE, 8'h07, "R2 pointer stays on MR2");
    readExp(MODE, 8'h07, "R2 pointer sticky");
    busWrite(CMD, 8'h10);
    readExp(MODE, 8'h13, "R2 MR1 after pointer reset");
    readExp(MODE, 8'h07, "R2 MR2 after one access");
    // R1 decode
    busWrite(8'h20, 8'hEE);
    busWrite(CMD, 8'h10);
    readExp(MODE, 8'h13, "R1 foreign write ignored");
    readExp(8'h22, 8'h00, "R1 foreign read");
    readExp(8'h38, 8'h00, "R1 unmapped nibble");
    readExp(8'h31, 8'h00, "R1 odd address");
    busWrite(STAT, 8'hFF);
    readExp(STAT, 8'h00, "R1 clock-select write ignored");
    // R5 / R7 / R6 / R9 receive path
    chk(rxReady == 0, "R5 disabled not ready", rxReady, 0);
    busWrite(CMD, 8'h01);
    chk(rxReady == 1, "R3 receiver enable", rxReady, 1);
    pushRx(8'h41, 0);
    chk(snRx == 1, "R7 event on first byte", snRx, 1);
    pushRx(8'h42, 0);
    chk(snRx == 0, "R7 no event when non-empty", snRx, 0);
    readExp(STAT, 8'h01, "R5 rx ready bit");
    pushRx(8'h43, 0);
    chk(rxReady == 0, "R5 full not ready", rxReady, 0);
    readExp(STAT, 8'h03, "R5 full bit");
    pushRx(8'h44, 0);
    readExp(STAT, 8'h13, "R9 overrun set");
    readExp(HOLD, 8'h41, "R6 order 1");
    readExp(HOLD, 8'h42, "R6 order 2");
    readExp(STAT, 8'h11, "R5 not full after pop");
    readExp(HOLD, 8'h43, "R6 order 3");
    readExp(STAT, 8'h10, "R6 empty status");
    readExp(HOLD, 8'h43, "R6 empty read returns last");
    readExp(STAT, 8'h10, "R6 empty read no change");
    busWrite(CMD, 8'h40);
    readExp(STAT, 8'h00, "R9 error reset");
    pushRx(8'h51, 0);
    chk(snRx == 1, "R7 event after drain", snRx, 1);
    pushRx(8'h52, 0);
    readExp(HOLD, 8'h51, "R6 wrap 1");
    readExp(HOLD, 8'h52, "R6 wrap 2");
    busWrite(CMD, 8'h02);
    chk(rxReady == 0, "R3 receiver disable", rxReady, 0);
    pushRx(8'h55, 0);
    readExp(STAT, 8'h00, "R5 drop while disabled");
    busWrite(CMD, 8'h01);
    pushRx(8'h61, 0);
    busWrite(CMD, 8'h21);
    chk(rxReady == 0, "R4 rx reset disables", rxReady, 0);
    readExp(STAT, 8'h00, "R4 rx reset empties");
    // R8 break
    busWrite(CMD, 8'h01);
    pushRx(8'hAA, 1);
    chk(snBrk == 1 && snRx == 1, "R8 break events", {snBrk, snRx}, 3);
    readExp(STAT, 8'h81, "R8 break status");
    readExp(HOLD, 8'h00, "R8 break byte zero");
    chk(snBrk == 1, "R8 break change on read", snBrk, 1);
    readExp(STAT, 8'h00, "R8 break cleared by read");
    pushRx(8'hAA, 1);
    pushRx(8'hAA, 1);
    chk(snBrk == 0, "R8 no event while break set", snBrk, 0);
    readExp(STAT, 8'h81, "R8 second break status");
    busWrite(CMD, 8'h40);
    readExp(STAT, 8'h01, "R9 error reset clears break");
    readExp(HOLD, 8'h00, "R8 zero byte");
    chk(snBrk == 0, "R8 no change event after reset", snBrk, 0);
    readExp(HOLD, 8'h00, "R8 zero byte 2");
    // R10 / R3 transmit path
    busWrite(CMD, 8'h04);
    chk(snTx == 1, "R3 tx enable event", snTx, 1);
    readExp(STAT, 8'h0C, "R3 tx ready bits");
    writeThr(8'h5A, 1);
    chk(txValid == 1 && txByte == 8'h5A, "R10 byte presented", txByte, 8'h5A);
    readExp(STAT, 8'h00, "R10 busy clears ready");
    writeThr(8'h77, 0);
    chk(txByte == 8'h5A, "R10 write while busy dropped", txByte, 8'h5A);
    txReady = 1'b1;
    cyc();
    chk(txValid == 0 && snTx == 1, "R10 accept and event", {txValid, snTx}, 1);
    readExp(STAT, 8'h0C, "R10 ready after accept");
    writeThr(8'h3C, 1);
    cyc();
    chk(snTx == 1, "R10 event after second byte", snTx, 1);
    busWrite(CMD, 8'h08);
    readExp(STAT, 8'h00, "R3 tx disable");
    writeThr(8'h99, 0);
    chk(txValid == 0, "R10 write while not ready dropped", txValid, 0);
    busWrite(CMD, 8'h0C);
    readExp(STAT, 8'h00, "R3 disable wins");
    busWrite(CMD, 8'h04);
    busWrite(CMD, 8'h30);
    readExp(STAT, 8'h00, "R4 tx reset");
    // R4 other codes
    busWrite(CMD, 8'h50);
    chk(snAck == 1, "R4 break ack pulse", snAck, 1);
    busWrite(CMD, 8'hA0);
    chk(snAck == 0, "R4 unsupported code no pulse", snAck, 0);
    readExp(MODE, 8'h07, "R4 unsupported code keeps pointer");
    cyc();
    chk(txQ.size() == 0, "R10 all bytes sent", txQ.size(), 0);
    chk(rdQ.size() == 0, "R1 all reads answered", rdQ.size(), 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule